// File: doc/BRIEF.md
# Stereo Serial Audio Port

The block carries 16-bit stereo samples between an audio codec core and an external DSP or ASIC. It owns the serial link. It produces the bit clock and the frame sync, drives capture samples out on a serial data line, and assembles playback samples from a serial input line. The core gives it a bit-clock enable. Each pulse of that enable moves the serial clock by one half period. When the enable slows down, the clock is stretched and is never cut short.

Every sample travels in a 16-bit slot, most significant bit first, with the left channel ahead of the right. Capture data 8 or 4 bits wide is placed at the top of the slot and the bits below it are zero. There are three frame formats: a 64-clock frame with a one-clock sync pulse, a 32-clock frame in which sync marks the left half, and a 32-clock frame with a one-clock sync pulse. Received left and right samples are presented together with a single-cycle strobe.

Top module: `serial_audio_port`

## Requirements
- R1: After reset, `sclk_o`, `fsync_o`, `sdout_o` and `pb_valid_o` are low.
- R2: While `port_en_i` is low, or `fmt_i` is 3, `sclk_o` stays low (once it has fallen), `fsync_o` and `sdout_o` stay low, no `pb_valid_o` is produced, and `bit_tick_i` is ignored.
- R3: `sclk_o` changes only on the clock edge that follows a cycle with `bit_tick_i` high. While the port is active, each such edge toggles it, so no high phase is shorter than the spacing between ticks.
- R4: For `fmt_i` 0 the frame is 64 bits. The left slot occupies bits 0 to 15, the right slot bits 32 to 47, and every other bit is zero. `fsync_o` is high only during bit 63, the bit just before bit 0.
- R5: For `fmt_i` 1 the frame is 32 bits, with the left slot in bits 0 to 15 and the right slot in bits 16 to 31. `fsync_o` is high for bits 0 to 15 and low for bits 16 to 31.
- R6: For `fmt_i` 2 the frame is 32 bits with the same slots as `fmt_i` 1. `fsync_o` is high only during bit 31.
- R7: Slot data is sent MSB first. `sdout_o` and `fsync_o` change only when `sclk_o` rises, so each value is stable across the following falling edge.
- R8: `cap_width_i` 0 sends the 16-bit input unchanged. A value of 1 sends input bits 7:0 in slot bits 15:8 and zeros below. A value of 2 sends input bits 3:0 in slot bits 15:12 and zeros below. A value of 3 is treated as 0.
- R9: `sdin_i` is sampled when `sclk_o` falls, MSB first in each slot. After the falling edge of the right slot's LSB, `pb_left_o` and `pb_right_o` hold the frame's samples and `pb_valid_o` is high for exactly one cycle, while `sclk_o` is low.
- R10: Format and capture width are taken at the start of each frame. A change in the middle of a frame takes effect from the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| fmt_i | input | 2 | Frame format: 0 = 64-bit pulse, 1 = 32-bit left-high, 2 = 32-bit pulse, 3 = off |
| cap_width_i | input | 2 | Capture sample width: 0 = 16, 1 = 8, 2 = 4, 3 = 16 |
| bit_tick_i | input | 1 | Half-period enable for the serial clock |
| cap_left_i | input | 16 | Left capture sample, right-justified when narrow |
| cap_right_i | input | 16 | Right capture sample, right-justified when narrow |
| sdin_i | input | 1 | Serial playback data |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame sync |
| sdout_o | output | 1 | Serial capture data |
| pb_left_o | output | 16 | Received left sample |
| pb_right_o | output | 16 | Received right sample |
| pb_valid_o | output | 1 | One-cycle strobe for the received pair |

## Verification
In the 32-clock pulse format, the sync pulse and the right slot's LSB share bit 31. The same falling edge that captures the last playback bit therefore comes just before the rise that wraps the frame and loads new capture words. The bench runs this format back to back over two frames. It checks that the bit-31 sync appears in both frames, that each frame's right sample is completed, and that exactly two strobes occur. A second run raises the format-change request in the middle of a frame. The bench then checks that the old layout completes and that the new 64-bit layout and its new width start exactly at the next frame boundary.

// File: rtl/sap_pkg.sv
package sap_pkg;
  localparam int SLOT_W  = 16;
  localparam int BIT_W   = $clog2(4 * SLOT_W);
  localparam int SLOT_IW = $clog2(SLOT_W);
  localparam logic [BIT_W-1:0] SLOT_B = BIT_W'(SLOT_W);

  typedef enum logic [1:0] {
    FMT_ENH   = 2'd0,
    FMT_LR    = 2'd1,
    FMT_PULSE = 2'd2,
    FMT_OFF   = 2'd3
  } sap_fmt_e;

  function automatic logic [BIT_W-1:0] last_bit(sap_fmt_e f);
    return (f == FMT_ENH) ? BIT_W'(4 * SLOT_W - 1) : BIT_W'(2 * SLOT_W - 1);
  endfunction

  function automatic logic [BIT_W-1:0] right_base(sap_fmt_e f);
    return (f == FMT_ENH) ? BIT_W'(2 * SLOT_W) : SLOT_B;
  endfunction

  function automatic logic in_slot(logic [BIT_W-1:0] b, logic [BIT_W-1:0] base);
    return (b >= base) && (b < base + SLOT_B);
  endfunction

  // narrow samples go to the top of the slot, zero below
  function automatic logic [SLOT_W-1:0] align_slot(logic [SLOT_W-1:0] x, logic [1:0] w);
    case (w)
      2'd1:    return {x[7:0], {(SLOT_W-8){1'b0}}};
      2'd2:    return {x[3:0], {(SLOT_W-4){1'b0}}};
      default: return x;
    endcase
  endfunction
endpackage

// File: rtl/sap_clkgen.sv
module sap_clkgen
  import sap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  sap_fmt_e         fmt_i,
  input  logic             tick_i,
  output logic             sclk_o,
  output logic             run_o,
  output logic [BIT_W-1:0] bit_o,
  output sap_fmt_e         fmt_o,
  output logic             frame_start_o,
  output logic             fall_o,
  output logic             fsync_o
);
  logic             sclk_q, run_q, active, wrap;
  logic [BIT_W-1:0] bit_q;
  sap_fmt_e         fmt_q;

  assign active = en_i && (fmt_i != FMT_OFF);
  assign wrap   = (bit_q == last_bit(fmt_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      run_q  <= 1'b0;
      bit_q  <= last_bit(FMT_ENH);
      fmt_q  <= FMT_ENH;
    end else if (!active) begin
      if (tick_i) sclk_q <= 1'b0;  // drop only on a tick: no short high phase
      run_q <= 1'b0;
      bit_q <= last_bit(fmt_i);
      fmt_q <= fmt_i;
    end else if (tick_i) begin
      sclk_q <= !sclk_q;
      if (!sclk_q) begin
        run_q <= 1'b1;
        if (wrap) begin
          bit_q <= '0;
          fmt_q <= fmt_i;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign sclk_o        = sclk_q;
  assign run_o         = run_q;
  assign bit_o         = bit_q;
  assign fmt_o         = fmt_q;
  assign frame_start_o = active && tick_i && !sclk_q && wrap;
  assign fall_o        = active && tick_i && sclk_q && run_q;
  assign fsync_o       = run_q && ((fmt_q == FMT_LR) ? (bit_q < SLOT_B) : wrap);

  assert_sclk_on_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_q != $past(sclk_q)) |-> $past(tick_i));
endmodule

// File: rtl/sap_tx.sv
module sap_tx
  import sap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [1:0]        width_i,
  input  logic [SLOT_W-1:0] left_i,
  input  logic [SLOT_W-1:0] right_i,
  input  logic              run_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  sap_fmt_e          fmt_i,
  output logic              sdout_o
);
  logic [SLOT_W-1:0]  left_q, right_q;
  logic [SLOT_IW-1:0] idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q  <= '0;
      right_q <= '0;
    end else if (frame_start_i) begin
      left_q  <= align_slot(left_i, width_i);
      right_q <= align_slot(right_i, width_i);
    end
  end

  // slot bases are multiples of SLOT_W, so the low bits give the position in the slot
  assign idx = ~bit_i[SLOT_IW-1:0];

  always_comb begin
    sdout_o = 1'b0;
    if (run_i) begin
      if (in_slot(bit_i, '0))                     sdout_o = left_q[idx];
      else if (in_slot(bit_i, right_base(fmt_i))) sdout_o = right_q[idx];
    end
  end
endmodule

// File: rtl/sap_rx.sv
module sap_rx
  import sap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              sdin_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  sap_fmt_e          fmt_i,
  output logic [SLOT_W-1:0] left_o,
  output logic [SLOT_W-1:0] right_o,
  output logic              valid_o
);
  logic [SLOT_W-1:0] lsh_q, rsh_q;
  logic              in_l, in_r, last_r;

  assign in_l   = in_slot(bit_i, '0);
  assign in_r   = in_slot(bit_i, right_base(fmt_i));
  assign last_r = in_r && (&bit_i[SLOT_IW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsh_q   <= '0;
      rsh_q   <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (fall_i) begin
        if (in_l) lsh_q <= {lsh_q[SLOT_W-2:0], sdin_i};
        if (in_r) rsh_q <= {rsh_q[SLOT_W-2:0], sdin_i};
        if (last_r) begin
          left_o  <= lsh_q;
          right_o <= {rsh_q[SLOT_W-2:0], sdin_i};
          valid_o <= 1'b1;
        end
      end
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/serial_audio_port.sv
module serial_audio_port
  import sap_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_en_i,
  input  logic [1:0]        fmt_i,
  input  logic [1:0]        cap_width_i,
  input  logic              bit_tick_i,
  input  logic [SLOT_W-1:0] cap_left_i,
  input  logic [SLOT_W-1:0] cap_right_i,
  input  logic              sdin_i,
  output logic              sclk_o,
  output logic              fsync_o,
  output logic              sdout_o,
  output logic [SLOT_W-1:0] pb_left_o,
  output logic [SLOT_W-1:0] pb_right_o,
  output logic              pb_valid_o
);
  logic             run, frame_start, fall;
  logic [BIT_W-1:0] bit_idx;
  sap_fmt_e         fmt_cur;

  sap_clkgen u_clkgen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (port_en_i),
    .fmt_i         (sap_fmt_e'(fmt_i)),
    .tick_i        (bit_tick_i),
    .sclk_o        (sclk_o),
    .run_o         (run),
    .bit_o         (bit_idx),
    .fmt_o         (fmt_cur),
    .frame_start_o (frame_start),
    .fall_o        (fall),
    .fsync_o       (fsync_o)
  );

  sap_tx u_tx (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .width_i       (cap_width_i),
    .left_i        (cap_left_i),
    .right_i       (cap_right_i),
    .run_i         (run),
    .bit_i         (bit_idx),
    .fmt_i         (fmt_cur),
    .sdout_o       (sdout_o)
  );

  sap_rx u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fall_i  (fall),
    .sdin_i  (sdin_i),
    .bit_i   (bit_idx),
    .fmt_i   (fmt_cur),
    .left_o  (pb_left_o),
    .right_o (pb_right_o),
    .valid_o (pb_valid_o)
  );

  assert_idle_clock_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!port_en_i && !sclk_o) |=> !sclk_o);

  assert_sdout_on_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && $past(run) && (sdout_o != $past(sdout_o))) |-> (sclk_o && !$past(sclk_o)));

  assert_valid_while_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_valid_o |-> !sclk_o);
endmodule

// File: tb/serial_audio_port_test.sv
module serial_audio_port_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        port_en = 1'b0;
  logic [1:0]  fmt = 2'd1;
  logic [1:0]  cap_width = 2'd0;
  logic        bit_tick = 1'b0;
  logic [15:0] cap_left = '0, cap_right = '0;
  logic        sdin = 1'b0;
  logic        sclk, fsync, sdout, pb_valid;
  logic [15:0] pb_left, pb_right;

  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_audio_port uut (
    .clk_i(clk), .rst_ni(rst_ni), .port_en_i(port_en), .fmt_i(fmt),
    .cap_width_i(cap_width), .bit_tick_i(bit_tick), .cap_left_i(cap_left),
    .cap_right_i(cap_right), .sdin_i(sdin), .sclk_o(sclk), .fsync_o(fsync),
    .sdout_o(sdout), .pb_left_o(pb_left), .pb_right_o(pb_right), .pb_valid_o(pb_valid)
  );

  // tick source
  logic tick_on = 1'b0;
  int   tick_gap = 2;
  int   gap_ctr = 0;
  initial forever begin
    @(negedge clk);
    if (tick_on && gap_ctr >= tick_gap - 1) begin bit_tick = 1'b1; gap_ctr = 0; end
    else begin bit_tick = 1'b0; if (tick_on) gap_ctr++; end
  end

  // serial peer model
  logic sd_rec [0:199];
  logic fs_rec [0:199];
  logic tx_bits[0:199];
  int   bidx = 0, vcnt = 0, hi_len = 0, min_hi = 1000;
  logic sclk_prev = 1'b0;
  logic [15:0] got_l, got_r;
  initial forever begin
    @(negedge clk);
    if (sclk && !sclk_prev) begin
      if (bidx < 200) begin
        sd_rec[bidx] = sdout;
        fs_rec[bidx] = fsync;
        sdin = tx_bits[bidx];
      end else sdin = 1'b0;
      bidx++;
      hi_len = 1;
    end else if (sclk) hi_len++;
    if (!sclk && sclk_prev && hi_len < min_hi) min_hi = hi_len;
    sclk_prev = sclk;
    if (pb_valid) begin vcnt++; got_l = pb_left; got_r = pb_right; end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_align(logic [15:0] x, int w);
    if (w == 1) return {x[7:0], 8'h00};
    if (w == 2) return {x[3:0], 12'h000};
    return x;
  endfunction

  function automatic int flen(int f);
    return (f == 0) ? 64 : 32;
  endfunction

  function automatic logic slot_bit(int f, logic [15:0] l, logic [15:0] r, int k);
    int rb = (f == 0) ? 32 : 16;
    if (k < 16) return l[15-k];
    if (k >= rb && k < rb + 16) return r[15-(k-rb)];
    return 1'b0;
  endfunction

  function automatic logic sync_bit(int f, int k);
    if (f == 1) return k < 16;
    return k == flen(f) - 1;
  endfunction

  // two frames: A with (fa,wa), B with (fb,wb); switch applied at bit index sw
  task automatic do_run(input string tag, input int fa, input int wa, input int fb,
                        input int wb, input int ga, input int gb, input int sw,
                        input logic [15:0] cl, input logic [15:0] cr,
                        input logic [15:0] pl, input logic [15:0] pr);
    int la = flen(fa), lb = flen(fb), t = 0;
    logic [63:0] act_d, exp_d, act_f, exp_f;
    port_en = 1'b0;
    tick_on = 1'b1;
    tick_gap = ga;
    repeat (12) @(negedge clk);
    for (int k = 0; k < 200; k++) tx_bits[k] = 1'b0;
    for (int k = 0; k < la; k++) tx_bits[k] = slot_bit(fa, pl, pr, k);
    for (int k = 0; k < lb; k++) tx_bits[la+k] = slot_bit(fb, pl, pr, k);
    fmt = 2'(fa); cap_width = 2'(wa); cap_left = cl; cap_right = cr;
    bidx = 0; vcnt = 0; min_hi = 1000;
    port_en = 1'b1;
    while (bidx < la + lb + 1 && t < 8000) begin
      @(negedge clk);
      t++;
      if (sw >= 0 && bidx >= sw) begin fmt = 2'(fb); cap_width = 2'(wb); tick_gap = gb; end
    end
    port_en = 1'b0;
    repeat (8) @(negedge clk);
    act_d = '0; exp_d = '0; act_f = '0; exp_f = '0;
    for (int k = 0; k < la; k++) begin
      act_d[k] = sd_rec[k]; exp_d[k] = slot_bit(fa, exp_align(cl, wa), exp_align(cr, wa), k);
      act_f[k] = fs_rec[k]; exp_f[k] = sync_bit(fa, k);
    end
    chk(act_d == exp_d, tag, "first frame sdout", act_d, exp_d);
    chk(act_f == exp_f, tag, "first frame fsync", act_f, exp_f);
    act_d = '0; exp_d = '0; act_f = '0; exp_f = '0;
    for (int k = 0; k < lb; k++) begin
      act_d[k] = sd_rec[la+k]; exp_d[k] = slot_bit(fb, exp_align(cl, wb), exp_align(cr, wb), k);
      act_f[k] = fs_rec[la+k]; exp_f[k] = sync_bit(fb, k);
    end
    chk(act_d == exp_d, tag, "second frame sdout", act_d, exp_d);
    chk(act_f == exp_f, tag, "second frame fsync", act_f, exp_f);
    chk({got_l, got_r} == {pl, pr}, {tag, " R9"}, "received pair", {got_l, got_r}, {pl, pr});
    chk(vcnt == 2, {tag, " R9"}, "strobe count", 64'(vcnt), 64'd2);
    chk(min_hi >= ((ga < gb) ? ga : gb), {tag, " R3"}, "min sclk high", 64'(min_hi),
        64'((ga < gb) ? ga : gb));
  endtask

  task automatic test_reset();
    @(negedge clk);
    chk(sclk == 1'b0, "R1", "sclk", 64'(sclk), 64'd0);
    chk(fsync == 1'b0, "R1", "fsync", 64'(fsync), 64'd0);
    chk(sdout == 1'b0, "R1", "sdout", 64'(sdout), 64'd0);
    chk(pb_valid == 1'b0, "R1", "pb_valid", 64'(pb_valid), 64'd0);
  endtask

  task automatic test_disabled();
    int act = 0;
    port_en = 1'b0; fmt = 2'd1; tick_on = 1'b1; tick_gap = 2;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk || fsync || sdout || pb_valid) act++;
    end
    chk(act == 0, "R2", "activity with enable low", 64'(act), 64'd0);
    act = 0;
    port_en = 1'b1; fmt = 2'd3;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclk || fsync || sdout || pb_valid) act++;
    end
    chk(act == 0, "R2", "activity with format off", 64'(act), 64'd0);
    port_en = 1'b0;
  endtask

  task automatic test_lr16();
    do_run("R5 R7", 1, 0, 1, 0, 2, 2, -1, 16'hA5C3, 16'h3C81, 16'hB00F, 16'h1234);
  endtask

  task automatic test_enh16();
    do_run("R4 R7", 0, 0, 0, 0, 2, 2, -1, 16'h8001, 16'hFFFE, 16'h5AA5, 16'hC3E1);
  endtask

  task automatic test_pulse8();
    do_run("R6 R8", 2, 1, 2, 1, 2, 2, -1, 16'hFF96, 16'h127E, 16'h0F0F, 16'h8888);
  endtask

  task automatic test_lr4();
    do_run("R8", 1, 2, 1, 2, 3, 3, -1, 16'hFFFB, 16'h0006, 16'hFFFF, 16'h0001);
  endtask

  task automatic test_enh_w3();
    do_run("R8", 0, 3, 0, 3, 2, 2, -1, 16'h7E01, 16'h9A02, 16'h8000, 16'h0000);
  endtask

  task automatic test_stretch();
    do_run("R3", 1, 0, 1, 0, 2, 5, 10, 16'hDEAD, 16'hBEEF, 16'h6B3D, 16'hE817);
  endtask

  task automatic test_fmt_switch();
    do_run("R10", 1, 0, 0, 1, 2, 2, 5, 16'hC0A5, 16'h55AA, 16'h2468, 16'h9BDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_reset();
    test_disabled();
    test_lr16();
    test_enh16();
    test_pulse8();
    test_lr4();
    test_enh_w3();
    test_stretch();
    test_fmt_switch();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule